// File: doc/BRIEF.md
# Scalar AES Encryption Round Step Unit

This unit is the execute-stage datapath for the two scalar AES encryption instructions of a 32-bit core. One instruction handles one byte of state. It takes the byte of the second source operand that a 2-bit immediate names and passes it through the forward AES substitution box. The substituted byte is then spread into a 32-bit column word. The middle-round form applies the column-mixing coefficients 2, 1, 1, 3. The final-round form places the byte alone in the lowest lane. The word is rotated left by eight times the byte index and XORed into the first source operand, which holds the state word built up so far. Four such instructions, one per byte index, therefore build one output column of an AES round. The nine inner rounds of AES-128 use the middle-round form, and the last round, which has no column mixing, uses the final-round form.

Operands enter on a valid/ready stream and the result leaves on a second valid/ready stream. A transfer happens on a rising clock edge when valid and ready are both high. Once the producer raises `in_valid`, it holds it and the operands steady until the transfer. The parameter `LATENCY` selects one of two builds. With 0 the unit is purely combinational: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. With 1 a single output register sits between the streams. It accepts new operands whenever it is empty or is being drained in the same cycle. While the consumer stalls, it holds the result unchanged.

Top module: `aes32_round_unit`

## Requirements
- R1: Operand `in_bsel` = k selects byte k of `in_rs2`, bits [8k+7:8k], as the substitution input.
- R2: The substitution is the forward AES S-box (multiplicative inverse in GF(2^8) modulo 0x11B, with zero mapped to zero, followed by the standard affine map with constant 0x63). For example, 0x00 maps to 0x63, 0x01 to 0x7C and 0x53 to 0xED.
- R3: With `in_mid` = 0 (final-round form), the result is `in_rs1` XOR ({24'b0, s} rotated left by 8k). Only bits of lane k can differ from `in_rs1`.
- R4: With `in_mid` = 1 (middle-round form), the column word is {3·s, s, s, 2·s}, from bit 31 down to bit 0. It is rotated left by 8k and XORed with `in_rs1`.
- R5: Multiplication by 2 reduces by 0x1B when the top bit of s is set, and 3·s equals 2·s XOR s.
- R6: With `LATENCY` = 1, operands accepted at an edge appear on `out_rd` with `out_valid` high after that edge. With no transfer in and the output drained, `out_valid` falls.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_rd` hold their values.
- R8: With `LATENCY` = 1, `in_ready` is high exactly when the output register is empty or `out_ready` is high. With `LATENCY` = 0, `in_ready` equals `out_ready`, `out_valid` equals `in_valid`, and the result is present in the same cycle.
- R9: After reset `out_valid` is low and, with `LATENCY` = 1, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Unit can take operands |
| in_rs1 | input | 32 | Accumulated state word |
| in_rs2 | input | 32 | Word that supplies the substituted byte |
| in_bsel | input | 2 | Byte index k |
| in_mid | input | 1 | 1 selects the middle-round form, 0 the final-round form |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_rd | output | 32 | Destination value |

## Verification
A wrong S-box or column-mixing term shows on `out_rd` for the very operands that reach it. That happens in the cycle of the transfer when `LATENCY` is 0, and one edge later when it is 1. A sweep of all 256 byte values in the middle-round form exposes any single wrong substitution entry in both the plain and the doubled lanes. A wrong byte index or rotation moves the change into another lane, so an all-ones or patterned `in_rs1` makes it visible at once. A corrupted output-register state shows as a result that changes during a stall, as `in_ready` stuck low, or as a stale `out_valid` one cycle after draining.

// File: rtl/aes32_pkg.sv
package aes32_pkg;
  typedef logic [7:0]  gf8_t;
  typedef logic [31:0] word_t;

  // multiply by the field element 2, reduction polynomial 0x11B
  function automatic gf8_t gf_dbl(gf8_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic gf8_t gf_mul(gf8_t a, gf8_t b);
    gf8_t acc = 8'h00;
    gf8_t run = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ run;
      run = gf_dbl(run);
    end
    return acc;
  endfunction

  // a^254 by repeated squaring; zero maps to zero
  function automatic gf8_t gf_inv(gf8_t a);
    gf8_t pw  = a;
    gf8_t acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gf_mul(pw, pw);
      acc = gf_mul(acc, pw);
    end
    return acc;
  endfunction

  function automatic gf8_t rotl8(gf8_t b, int n);
    return gf8_t'((b << n) | (b >> (8 - n)));
  endfunction

  function automatic gf8_t sub_fwd(gf8_t a);
    gf8_t v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes32_lane_sub.sv
module aes32_lane_sub
  import aes32_pkg::*;
#(
  parameter int LANES = 4,
  localparam int SELW = $clog2(LANES)
) (
  input  word_t           src,
  input  logic [SELW-1:0] sel,
  output gf8_t            sub
);
  gf8_t lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = src[8*g +: 8];
  end

  gf8_t picked;
  assign picked = lane[sel];
  assign sub    = sub_fwd(picked);
endmodule

// File: rtl/aes32_col_merge.sv
module aes32_col_merge
  import aes32_pkg::*;
#(
  parameter int LANES = 4,
  localparam int SELW = $clog2(LANES)
) (
  input  gf8_t            sub,
  input  logic [SELW-1:0] sel,
  input  logic            mid,
  input  word_t           acc,
  output word_t           res
);
  gf8_t  dbl;
  word_t col;
  word_t rot;

  assign dbl = gf_dbl(sub);

  always_comb begin
    if (mid) col = {dbl ^ sub, sub, sub, dbl};
    else     col = {24'h0, sub};
  end

  always_comb begin
    rot = col;
    for (int k = 1; k < LANES; k++) begin
      if (int'(sel) == k) rot = (col << (8 * k)) | (col >> (32 - 8 * k));
    end
  end

  assign res = acc ^ rot;
endmodule

// File: rtl/aes32_hold_stage.sv
module aes32_hold_stage #(
  parameter int LATENCY = 1,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  if (LATENCY == 0) begin : g_wire
    assign dn_valid = up_valid;
    assign dn_data  = up_data;
    assign up_ready = dn_ready;
  end else begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;

    assign up_ready = !full_q || dn_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        full_q <= 1'b0;
      else if (up_ready) full_q <= up_valid;
    end

    always_ff @(posedge clk) begin
      if (up_ready && up_valid) data_q <= up_data;
    end

    assign dn_valid = full_q;
    assign dn_data  = data_q;

    AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> dn_valid); // R7
    AST_STALL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> $stable(dn_data)); // R7
    AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid && up_ready |=> dn_valid); // R6
    AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid && dn_ready |=> !dn_valid); // R6
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !dn_valid |-> up_ready); // R8
  end
endmodule

// File: rtl/aes32_round_unit.sv
module aes32_round_unit
  import aes32_pkg::*;
#(
  parameter int LATENCY = 1,
  localparam int LANES = 4,
  localparam int SELW = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_rs1,
  input  logic [31:0]     in_rs2,
  input  logic [SELW-1:0] in_bsel,
  input  logic            in_mid,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_rd
);
  gf8_t  sub_b;
  word_t mix_rd;

  aes32_lane_sub #(.LANES(LANES)) u_sub (
    .src(in_rs2), .sel(in_bsel), .sub(sub_b)
  );

  aes32_col_merge #(.LANES(LANES)) u_merge (
    .sub(sub_b), .sel(in_bsel), .mid(in_mid), .acc(in_rs1), .res(mix_rd)
  );

  aes32_hold_stage #(.LATENCY(LATENCY), .W(32)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(mix_rd),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_rd)
  );

  AST_FINAL_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_mid |-> $countones(in_rs1 ^ mix_rd) <= 8); // R3
  AST_MID_LANES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mid |->
      ((in_rs1 ^ mix_rd) >> (8 * ((int'(in_bsel) + 1) % 4)) & 32'hFF) ==
      ((in_rs1 ^ mix_rd) >> (8 * ((int'(in_bsel) + 2) % 4)) & 32'hFF)); // R4
endmodule

// File: tb/aes32_round_unit_test.sv
module aes32_round_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [31:0] in_rs1 = '0, in_rs2 = '0, out_rd;
  logic [1:0]  in_bsel = '0;
  logic        in_mid = 1'b0;

  logic        z_valid = 1'b0, z_oready = 1'b1, z_iready, z_ovalid;
  logic [31:0] z_rs1 = '0, z_rs2 = '0, z_rd;
  logic [1:0]  z_bsel = '0;
  logic        z_mid = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  aes32_round_unit #(.LATENCY(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_bsel(in_bsel), .in_mid(in_mid),
    .out_valid(out_valid), .out_ready(out_ready), .out_rd(out_rd));

  aes32_round_unit #(.LATENCY(0)) uut0 (
    .clk(clk), .rst_n(rst_n), .in_valid(z_valid), .in_ready(z_iready),
    .in_rs1(z_rs1), .in_rs2(z_rs2), .in_bsel(z_bsel), .in_mid(z_mid),
    .out_valid(z_ovalid), .out_ready(z_oready), .out_rd(z_rd));

  // ---------- independent reference ----------
  function automatic logic [7:0] m2(logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction
  function automatic logic [7:0] mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= t;
      t = m2(t);
    end
    return r;
  endfunction
  function automatic logic [7:0] ref_sbox(logic [7:0] x);
    logic [7:0] v = 0;
    logic [7:0] o;
    for (int y = 1; y < 256; y++)
      if (x != 0 && mul(x, 8'(y)) == 8'h01) v = 8'(y);
    for (int b = 0; b < 8; b++)
      o[b] = v[b] ^ v[(b+4)%8] ^ v[(b+5)%8] ^ v[(b+6)%8] ^ v[(b+7)%8];
    return o ^ 8'h63;
  endfunction
  function automatic logic [31:0] ref_rd(logic [31:0] a, logic [31:0] b,
                                         logic [1:0] k, logic md);
    logic [7:0]  s = ref_sbox(b[8*k +: 8]);
    logic [31:0] w = md ? {m2(s) ^ s, s, s, m2(s)} : {24'h0, s};
    logic [63:0] d = {w, w} << (8 * k);
    return a ^ d[63:32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one transfer through the registered build, checked one edge later
  task automatic send1(string req, logic [31:0] a, logic [31:0] b,
                       logic [1:0] k, logic md);
    @(negedge clk);
    in_rs1 = a; in_rs2 = b; in_bsel = k; in_mid = md;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
    chk(req, out_rd, ref_rd(a, b, k, md));
  endtask

  task automatic t_reset;
    chk("R9 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R9 in_ready", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_known_sbox;
    send1("R2 s(00)", 32'h0, 32'h0000_0000, 2'd0, 1'b0);
    chk("R2 s(00)=63", out_rd, 32'h0000_0063);
    send1("R2 s(01)", 32'h0, 32'h0000_0100, 2'd1, 1'b0);
    chk("R2 s(01)=7C", out_rd, 32'h0000_7C00);
    send1("R2 s(53)", 32'h0, 32'h0053_0000, 2'd2, 1'b0);
    chk("R2 s(53)=ED", out_rd, 32'h00ED_0000);
  endtask

  task automatic t_bsel_final;
    for (int k = 0; k < 4; k++)
      send1("R1 R3 final lane", 32'hFFFF_FFFF, 32'h1A2B_3C4D, 2'(k), 1'b0);
  endtask

  task automatic t_mid_forms;
    for (int k = 0; k < 4; k++)
      send1("R4 mid rotate", 32'h0123_4567, 32'h5300_0053 ^ (32'h11 << (8*k)), 2'(k), 1'b1);
    // s(53)=ED, top bit set: 2*ED = DA^1B = C1, 3*ED = 2C
    send1("R5 reduce", 32'h0, 32'h0000_0053, 2'd0, 1'b1);
    chk("R5 word", out_rd, 32'h2CED_EDC1);
  endtask

  task automatic t_sweep;
    for (int x = 0; x < 256; x++)
      send1("R2 sweep", 32'h0, {24'h0, 8'(x)}, 2'd0, 1'b1);
  endtask

  task automatic t_backpressure;
    logic [31:0] ea = ref_rd(32'hAAAA_5555, 32'hDEAD_BEEF, 2'd3, 1'b1);
    logic [31:0] eb = ref_rd(32'h0F0F_0F0F, 32'h1234_5678, 2'd1, 1'b0);
    @(negedge clk);
    in_rs1 = 32'hAAAA_5555; in_rs2 = 32'hDEAD_BEEF; in_bsel = 2'd3; in_mid = 1'b1;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_rs1 = 32'h0F0F_0F0F; in_rs2 = 32'h1234_5678; in_bsel = 2'd1; in_mid = 1'b0;
    chk("R8 full stalled ready", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R7 hold valid", {31'b0, out_valid}, 32'd1);
    chk("R7 hold data", out_rd, ea);
    out_ready = 1'b1;
    #1;
    chk("R8 ready on drain", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 next word", out_rd, eb);
    @(negedge clk);
    chk("R6 drained", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_zero_latency;
    @(negedge clk);
    z_rs1 = 32'h8000_0001; z_rs2 = 32'h0100_0000; z_bsel = 2'd3; z_mid = 1'b1;
    z_valid = 1'b1; z_oready = 1'b0;
    #1;
    chk("R8 L0 ready follows", {31'b0, z_iready}, 32'd0);
    chk("R8 L0 valid follows", {31'b0, z_ovalid}, 32'd1);
    chk("R8 L0 same cycle", z_rd, ref_rd(32'h8000_0001, 32'h0100_0000, 2'd3, 1'b1));
    z_oready = 1'b1;
    #1;
    chk("R8 L0 ready high", {31'b0, z_iready}, 32'd1);
    z_valid = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_known_sbox();
    t_bsel_final();
    t_mid_forms();
    t_sweep();
    t_backpressure();
    t_zero_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule